// File: doc/BRIEF.md
# Step-Sequenced Programmable Clock Generator

This block produces an output clock whose frequency follows a list of steps held in an on-chip program RAM. Each step holds a divisor for the base clock and a rule for when the step ends. A step can end after a number of external trigger edges, after a number of output clock periods, or when the host forces it. The base clock is one of several clock-enable inputs, and a divide-by-256 prescaler can be placed in front of the step divisor to reach low output rates.

A host loads the program through a small register port. It places a word pointer, writes words through a data register that auto-increments, and starts the program with a run bit. While the program runs, a terminal flag in a step's flag word sends the sequence back to step 0. The recycle bit then decides whether the list loops or the block stops. Every step change raises a stretched strobe so that slow downstream logic can see it.

Top module: `stepclk_gen`

## Requirements
- R1: Step k uses RAM words 4k to 4k+3. Word 4k is the divisor. Word 4k+1 holds the flags: bits[1:0] set the terminating event (0 = trigger input 0, 1 = trigger input 1, 2 = output clock periods, 3 = none) and bit 15 is the end-of-list flag. Word 4k+2 is the low 16 bits of the 24-bit termination count, and bits[7:0] of word 4k+3 are its high 8 bits.
- R2: The host registers are selected by host_addr: 0 = control, 1 = word pointer, 2 = data, 3 = pointer clear, 4 = advance, 5 = current step. Every write or read of the data register accesses RAM at the pointer and then increments the pointer. A read of register 1 returns the pointer.
- R3: A write of 0 to register 1 sets the pointer to 0. A read of register 3 sets the pointer to 0 while the block is idle and is ignored while it runs.
- R4: Writing control bit0 = 1 while idle starts the program at step pointer/4 with clk_out high. Control bit0 reads back 1 while running, and a write with bit0 = 0 stops the block.
- R5: For a divisor N, clk_out has a period of N base ticks, is high for ceil(N/2) ticks and low for floor(N/2) ticks. N = 0 means 65536.
- R6: Control bit2 = 1 makes one base tick per 256 enables of the selected source. Control bits[4:3] pick base_en bit 0, 1 or 2, and the value 3 picks bit 0.
- R7: In output-clock mode, a step with count C ends after C full clk_out periods, and execution moves to the next step in RAM.
- R8: In trigger mode, each rising edge of the selected trigger input, after a two-flop synchronizer, counts one. Edges on the other input are ignored.
- R9: A count of 0 never ends a step by events.
- R10: A host read of register 4 while running ends the current step at once.
- R11: When a step with the end-of-list flag ends, the next step is step 0. With control bit1 (recycle) = 1 the block keeps running. With bit1 = 0 it goes idle, clk_out is low, and control bit0 reads 0.
- R12: A new step's divisor takes effect only at the end of the current clk_out period.
- R13: step_stb goes high for STB_LONG_CYC selected-source enables after each step end (5 by default; STB_SHORT_CYC = 1 when STB_LONG = 0).
- R14: After reset, the control register reads 0 and clk_out and step_stb are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_en | input | 3 | Base clock sources as clock enables |
| trig | input | 2 | Asynchronous external trigger inputs |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Host write |
| host_rd | input | 1 | Host read (side effects on registers 2, 3, 4) |
| host_addr | input | 3 | Host register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| clk_out | output | 1 | Generated output clock |
| step_stb | output | 1 | Stretched pulse on each step end |

## Verification
A table of divisors covers small even and odd values, so that a wrong rounding of the high phase shows up, and divisor 0 checks the 65536 wrap. Prescaler and source-select runs stretch the period by a known factor, which separates a tick path that is wrong from a divisor that is wrong. Termination is tried with output-clock counting, with trigger edges sent to both the selected and the unselected input, with a zero count, and with forced advances. Forced advances that land mid-period show whether a new divisor is applied early. Lists with recycle set and cleared show looping and stopping.

// File: rtl/stepclk_pkg.sv
package stepclk_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 24;
  localparam int NTRIG  = 2;
  localparam int NSRC   = 3;

  typedef enum logic [1:0] {
    TERM_TRIG0 = 2'd0,
    TERM_TRIG1 = 2'd1,
    TERM_OCLK  = 2'd2,
    TERM_HOST  = 2'd3
  } term_e;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_PTR   = 3'd1,
    RA_DATA  = 3'd2,
    RA_PZERO = 3'd3,
    RA_ADV   = 3'd4,
    RA_STEP  = 3'd5
  } reg_e;

  typedef struct packed {
    logic [1:0] src;
    logic       pre;
    logic       recycle;
  } ctrl_t;
endpackage

// File: rtl/stepclk_sync.sv
module stepclk_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q && !s3_q;
endmodule

// File: rtl/stepclk_host.sv
module stepclk_host
  import stepclk_pkg::*;
#(
  parameter int STEP_W = 8,
  localparam int PTR_W = STEP_W + 2,
  localparam int DEPTH = 1 << PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [2:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              active,
  input  logic [STEP_W-1:0] cur_step,
  input  logic [STEP_W-1:0] nxt_idx,
  output logic [WORD_W-1:0] cur_div,
  output term_e             cur_mode,
  output logic              cur_eol,
  output logic [WORD_W-1:0] nxt_div,
  output logic [CNT_W-1:0]  nxt_cnt,
  output ctrl_t             ctrl,
  output logic              start,
  output logic              stop,
  output logic              adv,
  output logic [STEP_W-1:0] start_step,
  output logic [PTR_W-1:0]  ptr
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              wr_ev, rd_ev;

  assign wr_ev = sel && wr;
  assign rd_ev = sel && rd;

  always_comb begin
    ptr_d  = ptr_q;
    ctrl_d = ctrl_q;
    if (wr_ev && addr == RA_CTRL) ctrl_d = ctrl_t'(wdata[4:1]);
    if (wr_ev && addr == RA_PTR) ptr_d = wdata[PTR_W-1:0];
    if ((wr_ev || rd_ev) && addr == RA_DATA) ptr_d = ptr_q + 1'b1;
    if (rd_ev && addr == RA_PZERO && !active) ptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ctrl_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ev && addr == RA_DATA) mem[ptr_q] <= wdata;
  end

  assign start      = wr_ev && addr == RA_CTRL && wdata[0] && !active;
  assign stop       = wr_ev && addr == RA_CTRL && !wdata[0] && active;
  assign adv        = rd_ev && addr == RA_ADV && active;
  assign start_step = ptr_q[PTR_W-1:2];
  assign ctrl       = ctrl_q;
  assign ptr        = ptr_q;

  // step read ports: current step and the step that would follow
  assign cur_div  = mem[{cur_step, 2'd0}];
  assign cur_mode = term_e'(mem[{cur_step, 2'd1}][1:0]);
  assign cur_eol  = mem[{cur_step, 2'd1}][WORD_W-1];
  assign nxt_div  = mem[{nxt_idx, 2'd0}];
  assign nxt_cnt  = {mem[{nxt_idx, 2'd3}][7:0], mem[{nxt_idx, 2'd2}]};

  always_comb begin
    case (addr)
      RA_CTRL: rdata = WORD_W'({ctrl_q, active});
      RA_PTR:  rdata = WORD_W'(ptr_q);
      RA_DATA: rdata = mem[ptr_q];
      RA_STEP: rdata = WORD_W'(cur_step);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/stepclk_seq.sv
module stepclk_seq
  import stepclk_pkg::*;
#(
  parameter int STEP_W  = 8,
  parameter int STB_CYC = 5,
  localparam int STB_W  = $clog2(STB_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              adv,
  input  logic [STEP_W-1:0] start_step,
  input  logic              recycle,
  input  logic [NTRIG-1:0]  trig_ev,
  input  logic              oclk_ev,
  input  logic              base_tick,
  input  term_e             cur_mode,
  input  logic              cur_eol,
  input  logic [CNT_W-1:0]  nxt_cnt,
  output logic              active,
  output logic [STEP_W-1:0] step,
  output logic [STEP_W-1:0] nxt_idx,
  output logic              done,
  output logic              step_stb
);
  logic              act_q, act_d;
  logic [STEP_W-1:0] step_q, step_d, nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [STB_W-1:0]  stb_q, stb_d;
  logic              ev;

  always_comb begin
    case (cur_mode)
      TERM_TRIG0: ev = trig_ev[0];
      TERM_TRIG1: ev = trig_ev[1];
      TERM_OCLK:  ev = oclk_ev;
      default:    ev = 1'b0;
    endcase
  end

  assign nxt     = cur_eol ? '0 : step_q + 1'b1;
  assign nxt_idx = act_q ? nxt : start_step;
  assign done    = act_q && (adv || (ev && cnt_q == CNT_W'(1)));

  always_comb begin
    act_d  = act_q;
    step_d = step_q;
    cnt_d  = cnt_q;
    if (start) begin
      act_d  = 1'b1;
      step_d = start_step;
      cnt_d  = nxt_cnt;
    end else if (stop) begin
      act_d = 1'b0;
    end else if (done) begin
      step_d = nxt;
      cnt_d  = nxt_cnt;
      if (cur_eol && !recycle) act_d = 1'b0;
    end else if (act_q && ev && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_comb begin
    stb_d = stb_q;
    if (done) stb_d = STB_W'(STB_CYC);
    else if (base_tick && stb_q != '0) stb_d = stb_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      step_q <= '0;
      cnt_q  <= '0;
      stb_q  <= '0;
    end else begin
      act_q  <= act_d;
      step_q <= step_d;
      cnt_q  <= cnt_d;
      stb_q  <= stb_d;
    end
  end

  assign active   = act_q;
  assign step     = step_q;
  assign step_stb = stb_q != '0;
endmodule

// File: rtl/stepclk_div.sv
module stepclk_div
  import stepclk_pkg::*;
#(
  parameter int PRE_DIV = 256,
  localparam int PRE_W  = $clog2(PRE_DIV),
  localparam int PH_W   = WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              pre,
  input  logic              active,
  input  logic              start,
  input  logic              done,
  input  logic [WORD_W-1:0] cur_div,
  input  logic [WORD_W-1:0] nxt_div,
  output logic              oclk_ev,
  output logic              clk_out
);
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [PH_W-1:0]   ph_q, ph_d, per_q, per_d, per_load, per_start, hi_len;
  logic [WORD_W-1:0] div_sel;
  logic              tick, last;

  function automatic logic [PH_W-1:0] expand(input logic [WORD_W-1:0] d);
    return (d == '0) ? PH_W'(1) << WORD_W : PH_W'(d);
  endfunction

  assign tick      = active && base_tick && (!pre || pre_q == PRE_W'(PRE_DIV - 1));
  assign last      = ph_q == per_q - 1'b1;
  assign oclk_ev   = tick && last;
  assign div_sel   = done ? nxt_div : cur_div;
  assign per_load  = expand(div_sel);
  assign per_start = expand(nxt_div);

  always_comb begin
    pre_d = pre_q;
    ph_d  = ph_q;
    per_d = per_q;
    if (start) begin
      pre_d = '0;
      ph_d  = '0;
      per_d = per_start;
    end else begin
      if (active && base_tick) pre_d = pre_q + 1'b1;
      if (tick) begin
        if (last) begin
          ph_d  = '0;
          per_d = per_load;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ph_q  <= '0;
      per_q <= PH_W'(2);
    end else begin
      pre_q <= pre_d;
      ph_q  <= ph_d;
      per_q <= per_d;
    end
  end

  assign hi_len  = (per_q + 1'b1) >> 1;
  assign clk_out = active && (ph_q < hi_len);
endmodule

// File: rtl/stepclk_gen.sv
module stepclk_gen
  import stepclk_pkg::*;
#(
  parameter int STEPS         = 256,
  parameter int PRE_DIV       = 256,
  parameter bit STB_LONG      = 1'b1,
  parameter int STB_SHORT_CYC = 1,
  parameter int STB_LONG_CYC  = 5,
  localparam int STEP_W       = $clog2(STEPS),
  localparam int PTR_W        = STEP_W + 2,
  localparam int STB_CYC      = STB_LONG ? STB_LONG_CYC : STB_SHORT_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   base_en,
  input  logic [NTRIG-1:0]  trig,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [2:0]        host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              clk_out,
  output logic              step_stb
);
  logic [1:0]        rs_q;
  logic              rst_s;
  logic              active, done, start, stop, adv, oclk_ev, base_tick;
  logic              cur_eol, pzero_rd;
  logic [STEP_W-1:0] step, nxt_idx, start_step;
  logic [PTR_W-1:0]  ptr;
  logic [WORD_W-1:0] cur_div, nxt_div;
  logic [CNT_W-1:0]  nxt_cnt;
  logic [NTRIG-1:0]  trig_ev;
  term_e             cur_mode;
  ctrl_t             ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  assign base_tick = (int'(ctrl.src) < NSRC) ? base_en[ctrl.src] : base_en[0];
  assign pzero_rd  = host_sel && host_rd && host_addr == RA_PZERO && !active;

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    stepclk_sync u_sync (.clk(clk), .rst_n(rst_s), .din(trig[g]), .rise(trig_ev[g]));
  end

  stepclk_host #(.STEP_W(STEP_W)) u_host (
    .clk(clk), .rst_n(rst_s), .sel(host_sel), .wr(host_wr), .rd(host_rd),
    .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
    .active(active), .cur_step(step), .nxt_idx(nxt_idx),
    .cur_div(cur_div), .cur_mode(cur_mode), .cur_eol(cur_eol),
    .nxt_div(nxt_div), .nxt_cnt(nxt_cnt), .ctrl(ctrl),
    .start(start), .stop(stop), .adv(adv), .start_step(start_step), .ptr(ptr)
  );

  stepclk_seq #(.STEP_W(STEP_W), .STB_CYC(STB_CYC)) u_seq (
    .clk(clk), .rst_n(rst_s), .start(start), .stop(stop), .adv(adv),
    .start_step(start_step), .recycle(ctrl.recycle), .trig_ev(trig_ev),
    .oclk_ev(oclk_ev), .base_tick(base_tick), .cur_mode(cur_mode),
    .cur_eol(cur_eol), .nxt_cnt(nxt_cnt), .active(active), .step(step),
    .nxt_idx(nxt_idx), .done(done), .step_stb(step_stb)
  );

  stepclk_div #(.PRE_DIV(PRE_DIV)) u_div (
    .clk(clk), .rst_n(rst_s), .base_tick(base_tick), .pre(ctrl.pre),
    .active(active), .start(start), .done(done), .cur_div(cur_div),
    .nxt_div(nxt_div), .oclk_ev(oclk_ev), .clk_out(clk_out)
  );
endmodule

// File: rtl/stepclk_chk.sv
module stepclk_chk #(
  parameter int STEP_W = 8,
  parameter int PTR_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic [STEP_W-1:0] step,
  input logic              done,
  input logic              eol,
  input logic              recycle,
  input logic              stop,
  input logic              pzero_rd,
  input logic [PTR_W-1:0]  ptr,
  input logic              clk_out,
  input logic              step_stb
);
  p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && eol && !recycle && !stop |=> !active && !clk_out);

  p_loop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && eol && recycle && !stop |=> active && step == '0);

  p_next_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !eol && !stop |=> step == STEP_W'($past(step) + 1'b1));

  p_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> step_stb);

  p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pzero_rd |=> ptr == '0);
endmodule

bind stepclk_gen stepclk_chk #(.STEP_W(STEP_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .active(active), .step(step), .done(done),
  .eol(cur_eol), .recycle(ctrl.recycle), .stop(stop), .pzero_rd(pzero_rd),
  .ptr(ptr), .clk_out(clk_out), .step_stb(step_stb)
);

// File: tb/test_stepclk_gen.sv
module test_stepclk_gen;
  logic        clk, rst_n;
  logic [2:0]  base_en;
  logic [1:0]  trig;
  logic        sel, wr, rd;
  logic [2:0]  addr;
  logic [15:0] wdata, rdata;
  logic        clk_out, step_stb;
  logic        tog_en;
  int          checks, errors;
  bit          done_flag;

  localparam logic [15:0] EOL  = 16'h8000;
  localparam logic [15:0] M_T0 = 16'd0, M_T1 = 16'd1, M_OC = 16'd2, M_NONE = 16'd3;
  localparam int STB_EXP = 5;
  // divisor, expected high ticks, expected low ticks
  localparam logic [47:0] VEC [6] = '{
    {16'd4, 16'd2, 16'd2}, {16'd5, 16'd3, 16'd2}, {16'd6, 16'd3, 16'd3},
    {16'd2, 16'd1, 16'd1}, {16'd9, 16'd5, 16'd4}, {16'd3, 16'd2, 16'd1}};

  stepclk_gen i_stepclk_gen (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .trig(trig),
    .host_sel(sel), .host_wr(wr), .host_rd(rd), .host_addr(addr),
    .host_wdata(wdata), .host_rdata(rdata), .clk_out(clk_out), .step_stb(step_stb));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      if (tog_en) base_en[1] = ~base_en[1];
    end
  end

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0; rd = 1'b0;
  endtask

  task automatic put_step(input int k, input logic [15:0] dv, input logic [15:0] fl,
                          input logic [23:0] cnt);
    hwr(3'd1, 16'(k * 4));
    hwr(3'd2, dv);
    hwr(3'd2, fl);
    hwr(3'd2, cnt[15:0]);
    hwr(3'd2, {8'h00, cnt[23:16]});
  endtask

  task automatic run(input logic [15:0] p, input logic [15:0] c);
    hwr(3'd1, p);
    hwr(3'd0, c | 16'd1);
  endtask

  task automatic pulse(input int i);
    @(negedge clk); trig[i] = 1'b1;
    repeat (3) @(negedge clk);
    trig[i] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    logic prev;
    int   g;
    hi = 0; lo = 0; g = 0;
    prev = clk_out;
    forever begin
      @(negedge clk); g++;
      if ((!prev && clk_out) || g > 5000) break;
      prev = clk_out;
    end
    while (clk_out && hi < 5000) begin hi++; @(negedge clk); end
    while (!clk_out && lo < 5000) begin lo++; @(negedge clk); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int hi, lo, n;
    bit saw1, saw0, alive;
    checks = 0; errors = 0; done_flag = 0;
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    base_en = 3'b001; trig = '0; tog_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R14 reset state
    check("R14 clk_out after reset", clk_out, 0);
    check("R14 step_stb after reset", step_stb, 0);
    hrd(3'd0, d);
    check("R14 control after reset", d, 0);

    // R2 / R3 pointer behaviour
    hwr(3'd1, 16'd8);
    hrd(3'd1, d);
    check("R2 pointer readback", d, 8);
    hwr(3'd2, 16'h1234);
    hrd(3'd1, d);
    check("R2 pointer increments on data write", d, 9);
    hrd(3'd3, d);
    hrd(3'd1, d);
    check("R3 pointer clear read while idle", d, 0);
    hwr(3'd1, 16'd5);
    hwr(3'd1, 16'd0);
    hrd(3'd1, d);
    check("R3 pointer write of zero", d, 0);

    // R5 divisor table
    for (int i = 0; i < 6; i++) begin
      hwr(3'd0, 16'd0);
      put_step(0, VEC[i][47:32], M_NONE | EOL, 24'd0);
      run(16'd0, 16'd2);
      measure(hi, lo);
      check($sformatf("R5 high ticks divisor %0d", VEC[i][47:32]), hi, int'(VEC[i][31:16]));
      check($sformatf("R5 low ticks divisor %0d", VEC[i][47:32]), lo, int'(VEC[i][15:0]));
    end
    hwr(3'd0, 16'd0);

    // R1 / R4 / R7 / R10 / R11: start at step 2, count output clocks
    put_step(2, 16'd4, M_OC, 24'd3);
    put_step(3, 16'd6, M_NONE | EOL, 24'd0);
    hwr(3'd1, 16'd8);
    hrd(3'd2, d);
    check("R1 word 4k holds the divisor", d, 4);
    hrd(3'd2, d);
    check("R1 word 4k+1 holds the flags", d, 2);
    run(16'd8, 16'd0);
    repeat (8) @(negedge clk);
    hrd(3'd5, d);
    check("R4 starts at pointer step", d, 2);
    repeat (4) @(negedge clk);
    hrd(3'd5, d);
    check("R7 step ends after three output clocks", d, 3);
    hrd(3'd3, d);
    hrd(3'd1, d);
    check("R3 pointer clear ignored while running", d, 8);
    measure(hi, lo);
    check("R7 next step divisor high", hi, 3);
    check("R7 next step divisor low", lo, 3);
    hrd(3'd4, d);
    hrd(3'd0, d);
    check("R11 stop at end of list, run bit", d & 16'd1, 0);
    check("R11 clk_out low when stopped", clk_out, 0);
    hrd(3'd5, d);
    check("R11 step returns to 0", d, 0);

    // R11 recycle loop
    put_step(0, 16'd2, M_OC, 24'd2);
    put_step(1, 16'd2, M_OC | EOL, 24'd2);
    run(16'd0, 16'd2);
    saw1 = 0; saw0 = 0; alive = 1;
    for (int i = 0; i < 20; i++) begin
      hrd(3'd5, d);
      if (d == 1) saw1 = 1;
      if (saw1 && d == 0) saw0 = 1;
      hrd(3'd0, d);
      if (d[0] == 1'b0) alive = 0;
    end
    check("R11 recycle wraps to step 0", int'(saw1 && saw0), 1);
    check("R11 recycle stays running", int'(alive), 1);
    hwr(3'd0, 16'd0);
    hrd(3'd0, d);
    check("R4 write of run 0 stops", d & 16'd1, 0);

    // R8 trigger counting
    put_step(0, 16'd4, M_T0, 24'd2);
    put_step(1, 16'd4, M_T1 | EOL, 24'd1);
    run(16'd0, 16'd0);
    pulse(1); pulse(1); pulse(1);
    hrd(3'd5, d);
    check("R8 unselected trigger ignored", d, 0);
    pulse(0);
    hrd(3'd5, d);
    check("R8 one of two edges", d, 0);
    pulse(0);
    hrd(3'd5, d);
    check("R8 two edges end step", d, 1);
    pulse(0);
    hrd(3'd5, d);
    check("R8 trigger 0 ignored in trigger 1 step", d, 1);
    pulse(1);
    hrd(3'd0, d);
    check("R8 trigger 1 ends final step", d & 16'd1, 0);

    // R9 zero count
    put_step(0, 16'd2, M_OC | EOL, 24'd0);
    run(16'd0, 16'd0);
    repeat (40) @(negedge clk);
    hrd(3'd0, d);
    check("R9 zero count never ends step", d & 16'd1, 1);
    hwr(3'd0, 16'd0);

    // R10 / R13 advance and strobe
    put_step(0, 16'd4, M_NONE, 24'd0);
    put_step(1, 16'd4, M_NONE | EOL, 24'd0);
    run(16'd0, 16'd2);
    repeat (3) @(negedge clk);
    check("R13 strobe low before step end", step_stb, 0);
    hrd(3'd4, d);
    n = 0;
    while (step_stb && n < 100) begin n++; @(negedge clk); end
    check("R13 strobe width", n, STB_EXP);
    hrd(3'd5, d);
    check("R10 advance ends step", d, 1);
    hwr(3'd0, 16'd0);

    // R12 divisor change waits for period end
    put_step(0, 16'd8, M_NONE, 24'd0);
    put_step(1, 16'd4, M_NONE | EOL, 24'd0);
    run(16'd0, 16'd2);
    hrd(3'd4, d);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      n = (n << 1) | int'(clk_out);
      @(negedge clk);
    end
    check("R12 pattern old period then new", n, 10'b1100001100);
    hwr(3'd0, 16'd0);

    // R6 prescaler and source select
    put_step(0, 16'd2, M_NONE | EOL, 24'd0);
    run(16'd0, 16'd6);
    measure(hi, lo);
    check("R6 prescaled high", hi, 256);
    check("R6 prescaled low", lo, 256);
    hwr(3'd0, 16'd0);
    put_step(0, 16'd4, M_NONE | EOL, 24'd0);
    tog_en = 1'b1;
    run(16'd0, 16'd10);
    measure(hi, lo);
    check("R6 source 1 high", hi, 4);
    check("R6 source 1 low", lo, 4);
    hwr(3'd0, 16'd0);
    tog_en = 1'b0;

    // R5 divisor zero means 65536
    put_step(0, 16'd0, M_NONE | EOL, 24'd0);
    run(16'd0, 16'd2);
    n = 0;
    while (clk_out && n < 70000) begin n++; @(negedge clk); end
    check("R5 divisor 0 high phase", n, 32768);
    hwr(3'd0, 16'd0);

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule